// File: doc/BRIEF.md
# Single-Word SPI Master with Register Access

This block is an SPI master that a processor drives through a small 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Software selects a clock mode, an 8- or 16-bit word and a clock prescaler. It then writes one word to the transmit register. The engine runs one full-duplex transfer on the serial clock, data-out and data-in lines. At the end of the transfer the engine stores the received word and raises a ready flag. Software polls the flag and clears it by writing zero.

Chip selection is independent of the shift engine. A 3-bit index chooses one of eight active-low select lines, and a separate assert bit drives that line low. A timing register moves the point at which the serial input is captured. At its reset value the input is captured on the sampling clock edge. At the alternative setting it is captured one system clock later, which tolerates slow devices at high serial rates.

Top module: `spi_word_master`

## Requirements
- R1: After reset all eight select outputs are high, the control register reads 0, the ready register reads 0, the timing register reads 0x40 (bits [7:6] = 1), and the serial clock is low.
- R2: Control bits [4:2] hold a select index and bit 0 an assert bit. With the assert bit at 1, exactly line `spi_cs_n[index]` is low. With it at 0, all lines are high. The lines follow the register in the cycle after the write.
- R3: A write to offset 0x08 while idle starts one transfer. The transfer sends 8 bits when configuration bit 5 is 0 and 16 bits when it is 1, taken from the low bits of the written value, most significant bit first.
- R4: Configuration bit 11 sets the serial clock idle level. Configuration bit 12 selects capture on the leading clock edge (0) or on the trailing clock edge (1). Output data changes on the other edge. All four combinations work.
- R5: After a transfer, offset 0x0C reads the received word, most significant bit first, zero-extended to 32 bits.
- R6: Offset 0x10 reads 1 once a transfer has finished. A write of value 0 to 0x10 clears it to 0, and a write of a nonzero value leaves it unchanged.
- R7: A write to offset 0x08 during a transfer is ignored. The word in flight is unchanged and no second transfer follows.
- R8: Timing bits [7:6] = 2 capture the serial input one system clock after the capture edge. Any other value captures it at the edge.
- R9: Configuration bits [4:0] = D make every serial clock half period last D+1 system clocks.
- R10: Outside a transfer the serial clock sits at the level set by configuration bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | NUM_CS | Active-low select lines |

## Verification
The assertions assume that software leaves the mode, width, prescaler and timing fields unchanged while a transfer runs. They also assume that the ready flag is cleared only between words. The bench always writes these fields while idle and waits for the ready flag before it reconfigures. The device model in the bench changes its data line only on sclk edges. In the late-capture test it toggles the line on every edge, so capture at the edge and capture one clock later give opposite words.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DIV_W   = 5;
  localparam int unsigned EDGE_W  = $clog2(2 * WORD_W);

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CFG  = 8'h04;
  localparam logic [7:0] OFF_TX   = 8'h08;
  localparam logic [7:0] OFF_RX   = 8'h0C;
  localparam logic [7:0] OFF_RDY  = 8'h10;
  localparam logic [7:0] OFF_TMG  = 8'h18;

  // index of the final clock edge of a word
  function automatic logic [EDGE_W-1:0] final_edge(input logic wide);
    final_edge = wide ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(2 * BYTE_W - 1);
  endfunction

  // keep only the bits that belong to the active word size
  function automatic logic [WORD_W-1:0] trim_word(input logic [WORD_W-1:0] w, input logic wide);
    trim_word = wide ? w : {{(WORD_W-BYTE_W){1'b0}}, w[BYTE_W-1:0]};
  endfunction
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || (div == '0));
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_CS)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              assert_en,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign cs_n[g] = !(assert_en && (idx == IDX_W'(g)));
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_word_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              wide,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  div,
  input  logic              late,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);
  logic              tail, phase, pend, wide_q, cpha_q;
  logic [EDGE_W-1:0] ecnt;
  logic [WORD_W-1:0] tx_sr, rx_sr;
  logic              tick, leading, samp_edge, accept;

  spi_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst_n(rst_n), .run(busy && !tail), .div(div), .tick(tick)
  );

  assign leading   = !ecnt[0];
  assign samp_edge = tick && (leading ^ cpha_q);
  assign accept    = start && !busy;
  assign sclk      = busy ? (cpol ^ phase) : cpol;
  assign mosi      = wide_q ? tx_sr[WORD_W-1] : tx_sr[BYTE_W-1];
  assign rx_word   = trim_word(rx_sr, wide_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; tail <= 1'b0; phase <= 1'b0; pend <= 1'b0; done <= 1'b0;
      wide_q <= 1'b0; cpha_q <= 1'b0; ecnt <= '0; tx_sr <= '0; rx_sr <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1; tail <= 1'b0; phase <= 1'b0; pend <= 1'b0; ecnt <= '0;
        tx_sr <= tx_word; rx_sr <= '0; wide_q <= wide; cpha_q <= cpha;
      end else if (busy) begin
        if (pend) begin
          rx_sr <= {rx_sr[WORD_W-2:0], miso};
          pend  <= 1'b0;
        end
        if (tail) begin
          busy <= 1'b0; tail <= 1'b0; done <= 1'b1;
        end else if (tick) begin
          phase <= !phase;
          ecnt  <= ecnt + 1'b1;
          if (samp_edge) begin
            if (late) pend  <= 1'b1;
            else      rx_sr <= {rx_sr[WORD_W-2:0], miso};
          end else if (ecnt != '0) begin
            tx_sr <= tx_sr << 1;
          end
          if (ecnt == final_edge(wide_q)) tail <= 1'b1;
        end
      end
    end
  end

  a_r4_mosi_hold_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
    busy && samp_edge |=> $stable(mosi));
  a_r9_clock_waits_for_tick: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(phase));
  a_r10_phase_home: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !phase);
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tail && start |=> busy && ecnt != '0 || tail || $past(ecnt) == '0);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic [IDX_W-1:0]  ctrl_idx;
  logic              ctrl_assert;
  logic              cfg_cpol, cfg_cpha, cfg_wide;
  logic [DIV_W-1:0]  cfg_div;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic              rdy_q;
  logic [1:0]        tmg_sel;
  logic              eng_busy, eng_done, tx_wr;
  logic [WORD_W-1:0] eng_rx;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    hit = (a == ADDR_W'(off));
  endfunction

  assign tx_wr = reg_wr && hit(reg_addr, OFF_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_idx <= '0; ctrl_assert <= 1'b0;
      cfg_cpol <= 1'b0; cfg_cpha <= 1'b0; cfg_wide <= 1'b0; cfg_div <= '0;
      tx_q <= '0; rx_q <= '0; rdy_q <= 1'b0; tmg_sel <= 2'd1;
    end else begin
      if (reg_wr && hit(reg_addr, OFF_CTRL)) begin
        ctrl_idx    <= reg_wdata[2 +: IDX_W];
        ctrl_assert <= reg_wdata[0];
      end
      if (reg_wr && hit(reg_addr, OFF_CFG)) begin
        cfg_cpol <= reg_wdata[11];
        cfg_cpha <= reg_wdata[12];
        cfg_wide <= reg_wdata[5];
        cfg_div  <= reg_wdata[DIV_W-1:0];
      end
      if (reg_wr && hit(reg_addr, OFF_TMG)) tmg_sel <= reg_wdata[7:6];
      if (tx_wr && !eng_busy) tx_q <= reg_wdata[WORD_W-1:0];
      if (eng_done) begin
        rx_q  <= eng_rx;
        rdy_q <= 1'b1;
      end else if (reg_wr && hit(reg_addr, OFF_RDY) && reg_wdata == '0) begin
        rdy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if      (hit(reg_addr, OFF_CTRL)) reg_rdata = {{(32-IDX_W-2){1'b0}}, ctrl_idx, 1'b0, ctrl_assert};
    else if (hit(reg_addr, OFF_CFG))  reg_rdata = {19'b0, cfg_cpha, cfg_cpol, 5'b0, cfg_wide, cfg_div};
    else if (hit(reg_addr, OFF_TX))   reg_rdata = {16'b0, tx_q};
    else if (hit(reg_addr, OFF_RX))   reg_rdata = {16'b0, rx_q};
    else if (hit(reg_addr, OFF_RDY))  reg_rdata = {31'b0, rdy_q};
    else if (hit(reg_addr, OFF_TMG))  reg_rdata = {24'b0, tmg_sel, 6'b0};
  end

  spi_shift_core i_core (
    .clk(clk), .rst_n(rst_n), .start(tx_wr), .tx_word(reg_wdata[WORD_W-1:0]),
    .wide(cfg_wide), .cpol(cfg_cpol), .cpha(cfg_cpha), .div(cfg_div),
    .late(tmg_sel == 2'd2), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(eng_busy), .done(eng_done), .rx_word(eng_rx)
  );

  spi_cs_decode #(.NUM_CS(NUM_CS)) i_cs (
    .idx(ctrl_idx), .assert_en(ctrl_assert), .cs_n(spi_cs_n)
  );

  a_r2_cs_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) == 32'(ctrl_assert));
  a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> rdy_q);
  a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy && $stable(cfg_cpol) |-> spi_sclk == $past(spi_sclk));
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy && tx_wr |=> $stable(tx_q));
endmodule

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [7:0]  spi_cs_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // device model state
  bit          armed = 0;
  bit          toggler = 0;
  bit          m_cpha = 0;
  int          m_bits = 8;
  int          m_edge = 0;
  logic [15:0] m_tx, m_rx;
  realtime     t_prev, t_first_gap;

  // {cpol, cpha, wide, div[4:0], tx[15:0], device_word[15:0]}
  localparam logic [39:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 5'd0, 16'h00A5, 16'h003C},
    {1'b0, 1'b1, 1'b0, 5'd1, 16'h005A, 16'h00C3},
    {1'b1, 1'b0, 1'b0, 5'd2, 16'h1281, 16'h007E},
    {1'b1, 1'b1, 1'b0, 5'd0, 16'h00FF, 16'h0001},
    {1'b0, 1'b0, 1'b1, 5'd1, 16'hBEEF, 16'h1234},
    {1'b0, 1'b1, 1'b1, 5'd0, 16'h8001, 16'hFFFE},
    {1'b1, 1'b0, 1'b1, 5'd3, 16'h0F0F, 16'hA55A},
    {1'b1, 1'b1, 1'b1, 5'd2, 16'hC3A5, 16'h6DB6}
  };

  spi_word_master i_spi_word_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #4 clk = !clk;

  always @(spi_sclk) begin
    if (armed) begin
      if (m_edge == 1) t_first_gap = $realtime - t_prev;
      t_prev = $realtime;
      if (toggler) begin
        spi_miso = !spi_miso;
      end else begin
        if ((m_edge % 2 == 0) ^ m_cpha) begin
          m_rx = {m_rx[14:0], spi_mosi};
        end else if (m_edge != 0) begin
          m_tx = m_tx << 1;
          spi_miso = m_tx[m_bits-1];
        end
      end
      m_edge++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_ready(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h10, v);
      if (v != 0) begin ok = 1; break; end
    end
  endtask

  task automatic prime(input logic cpha, input bit wide, input logic [15:0] dev);
    m_cpha = cpha; m_bits = wide ? 16 : 8; m_edge = 0; m_rx = '0;
    m_tx = dev;
    spi_miso = dev[m_bits-1];
    armed = 1;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 cs", {24'b0, spi_cs_n}, 32'hFF);
    check("R1 sclk", {31'b0, spi_sclk}, 32'h0);
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h10, v); check("R1 ready", v, 32'h0);
    rd(8'h18, v); check("R1 timing", v, 32'h40);

    // R2 select decode
    wr(8'h00, (32'd5 << 2) | 32'd1);
    check("R2 assert idx5", {24'b0, spi_cs_n}, 32'hDF);
    wr(8'h00, (32'd2 << 2) | 32'd1);
    check("R2 assert idx2", {24'b0, spi_cs_n}, 32'hFB);
    wr(8'h00, (32'd2 << 2));
    check("R2 release", {24'b0, spi_cs_n}, 32'hFF);
    wr(8'h00, 32'd1);

    // R3 R4 R5 R9 R10: table of transfers
    foreach (VEC[k]) begin
      logic cpol, cpha, wide;
      logic [4:0] div;
      logic [15:0] txw, dev, mask;
      {cpol, cpha, wide, div, txw, dev} = VEC[k];
      mask = wide ? 16'hFFFF : 16'h00FF;
      wr(8'h04, (32'(cpha) << 12) | (32'(cpol) << 11) | (32'(wide) << 5) | 32'(div));
      check("R10 idle level", {31'b0, spi_sclk}, {31'b0, cpol});
      wr(8'h10, 32'h0);
      prime(cpha, wide, dev);
      wr(8'h08, {16'hDEAD, txw});
      wait_ready(ok);
      armed = 0;
      check("R6 ready set", {31'b0, ok}, 32'h1);
      check("R3 R4 device received", {16'b0, m_rx & mask}, {16'b0, txw & mask});
      rd(8'h0C, v); check("R5 R4 word received", v, {16'b0, dev & mask});
      check("R9 half period", 32'(int'(t_first_gap)), 32'((div + 1) * 8));
      check("R10 idle after", {31'b0, spi_sclk}, {31'b0, cpol});
      check("R4 edge count", 32'(m_edge), 32'(2 * (wide ? 16 : 8)));
    end

    // R6 clear rules
    wr(8'h10, 32'h4); rd(8'h10, v); check("R6 nonzero write keeps", v, 32'h1);
    wr(8'h10, 32'h0); rd(8'h10, v); check("R6 zero write clears", v, 32'h0);

    // R7 write while busy ignored
    wr(8'h04, 32'd4);
    prime(1'b0, 0, 16'h0099);
    wr(8'h08, 32'h0033);
    repeat (6) @(negedge clk);
    wr(8'h08, 32'h00CC);
    wait_ready(ok);
    check("R7 first word kept", {16'b0, m_rx}, 32'h0033);
    wr(8'h10, 32'h0);
    repeat (80) @(negedge clk);
    armed = 0;
    rd(8'h10, v); check("R7 no second transfer", v, 32'h0);
    check("R7 edge count", 32'(m_edge), 32'd16);

    // R8 capture point, device toggles its line on every edge
    for (int s = 0; s < 4; s++) begin
      wr(8'h18, 32'(s) << 6);
      wr(8'h04, 32'd2);
      wr(8'h10, 32'h0);
      toggler = 1; spi_miso = 1'b0; m_edge = 0; armed = 1;
      wr(8'h08, 32'h0);
      wait_ready(ok);
      armed = 0; toggler = 0;
      rd(8'h0C, v);
      check("R8 capture point", v, (s == 2) ? 32'hFF : 32'h00);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule